// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores one received frame at a time into host memory through a ring of receive descriptors owned jointly by software and the controller. A frame is announced with its length, then its bytes arrive one per handshake. The block checks that it owns the descriptor at the current ring position, fills that descriptor's buffer, and chains into the following descriptors as long as bytes remain and descriptors stay owned. It then writes the flags and message byte count back, and releases the first descriptor last.

All memory traffic goes through a single 32-bit word port with a request/acknowledge handshake and byte enables. The ring base address, the ring length in descriptors, the descriptor layout style and the receiver enable are static inputs from the register unit. Each completed or error-terminated frame produces a one-cycle receive-interrupt pulse. The stream is always consumed in full, so bytes that are not stored are drained.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame is accepted for storage only when the ring base is nonzero, the receiver enable is high and the layout style is 2 or 3. Otherwise all of its bytes are drained, no memory request is issued and no interrupt is raised.
- R2: The descriptor at ring position p lies at ring base + 16*p. After each descriptor is used the position advances, and it returns to 0 when it reaches the ring length.
- R3: In style 2, word offset 0 holds the buffer address, offset 4 the flags and offset 8 the message count. In style 3, offsets 0 and 8 are exchanged.
- R4: If bit 31 (OWN) of the first descriptor's flags is 0, the frame is dropped after a single flags read. Nothing is written, no interrupt is raised and the ring position does not move.
- R5: The usable buffer size is the two's-complement negation of flags[11:0], taken modulo 4096. Stream byte k of a buffer goes to address buffer+k, packed little-endian into words written with matching byte enables. Buffers are word aligned.
- R6: A frame longer than 2048 bytes is stored as its first 2048 bytes. The remaining bytes are drained.
- R7: Each descriptor after the first has OWN cleared in its written-back flags, and STP (bit 25) is not set on it.
- R8: If the next descriptor is not owned while bytes remain, the current descriptor gets ERR (bit 30), BUFF (bit 26) and ENP (bit 24). Storing stops, the rest of the frame is drained, and the first descriptor is still released with an interrupt.
- R9: The descriptor holding the last stored byte gets ENP. Bits 11:0 of its message count word become the stored length plus 4, and bits 31:12 are kept as read.
- R10: The last memory write of a frame is the first descriptor's flags with OWN cleared and STP set. The receive interrupt is a single-cycle pulse that follows that write.
- R11: A memory request keeps its address, direction and write data stable until acknowledged. No request is issued out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ring_base_i | input | AW | Byte address of descriptor 0 |
| ring_len_i | input | POS_W+1 | Number of descriptors in the ring |
| layout_i | input | 8 | Descriptor layout style (2 or 3) |
| rx_en_i | input | 1 | Receiver enable |
| frm_start_i | input | 1 | Frame announce, taken when frm_ready_o is high |
| frm_len_i | input | LEN_W | Frame length in bytes |
| frm_ready_o | output | 1 | Idle, ready for a new frame |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 32 | Read data |
| rint_o | output | 1 | Receive-interrupt pulse |

## Verification
Four properties are checked on every cycle. A pending memory request stays stable until it is acknowledged. The interrupt lasts one cycle. The interrupt is always preceded by a write releasing a descriptor with STP set. A frame refused for lack of a ring base or enable starts no memory traffic. Whether the right descriptors carry the right flags, counts and buffer contents, and whether the ring position wraps, can only be seen in the directed scenarios: single-buffer frames in both layout styles, chained frames, an unowned first descriptor, descriptor exhaustion mid-frame, and an oversize frame under slow memory.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DW    = 32;
  localparam int SZW   = 12;
  localparam int OWN_B = 31;
  localparam int ERR_B = 30;
  localparam int BUF_B = 26;
  localparam int STP_B = 25;
  localparam int ENP_B = 24;
  localparam logic [7:0] STYLE_SEQ  = 8'd2;
  localparam logic [7:0] STYLE_SWAP = 8'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_FLG, S_RD_BUF, S_FILL, S_WR_DAT, S_ADV, S_RD_NXT,
    S_WR_CUR, S_RD_CNT, S_WR_CNT, S_WR_FST, S_DRAIN
  } rxr_state_e;

  typedef enum logic [1:0] {AFT_BUF, AFT_CNT, AFT_FST} rxr_after_e;
endpackage

// File: rtl/rxr_pos.sv
module rxr_pos #(
  parameter int AW    = 32,
  parameter int POS_W = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [POS_W:0] len_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] nxt_addr_o
);
  logic [POS_W-1:0] pos_q, pos_n;
  logic [POS_W:0]   inc;

  assign inc   = {1'b0, pos_q} + 1'b1;
  assign pos_n = (inc >= len_i) ? '0 : inc[POS_W-1:0];

  assign cur_addr_o = base_i + AW'({pos_q, 4'b0000});
  assign nxt_addr_o = base_i + AW'({pos_n, 4'b0000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (adv_i) pos_q <= pos_n;
  end
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack #(
  parameter int NB = 4,
  localparam int LW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [7:0]    byte_i,
  input  logic          clr_i,
  output logic [NB*8-1:0] word_o,
  output logic [NB-1:0] be_o,
  output logic [LW-1:0] lane_o
);
  logic [LW-1:0] lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lane_q <= '0;
    else if (clr_i)  lane_q <= '0;
    else if (load_i) lane_q <= lane_q + 1'b1;
  end
  assign lane_o = lane_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] b_q;
    logic       e_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_q <= '0;
        e_q <= 1'b0;
      end else if (load_i && lane_q == LW'(g)) begin
        b_q <= byte_i;
        e_q <= 1'b1;
      end else if (clr_i) begin
        e_q <= 1'b0;
      end
    end
    assign word_o[g*8 +: 8] = b_q;
    assign be_o[g]          = e_q;
  end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl import rxr_pkg::*; #(
  parameter int AW        = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 2048,
  parameter int NB        = 4,
  localparam int LW = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ring_base_i,
  input  logic [7:0]       layout_i,
  input  logic             rx_en_i,
  input  logic             frm_start_i,
  input  logic [LEN_W-1:0] frm_len_i,
  output logic             frm_ready_o,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic [DW-1:0]    pk_word_i,
  input  logic [NB-1:0]    pk_be_i,
  input  logic [LW-1:0]    pk_lane_i,
  output logic             pk_load_o,
  output logic             pk_clr_o,
  input  logic [AW-1:0]    cur_addr_i,
  input  logic [AW-1:0]    nxt_addr_i,
  output logic             adv_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [NB-1:0]    mem_be_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             rint_o
);
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_FRAME);

  rxr_state_e       state_q;
  rxr_after_e       after_q;
  logic [LEN_W-1:0] remain_q;
  logic [SZW-1:0]   store_q, tot_q, chunk_q;
  logic             sty3_q, is_first_q, rint_q;
  logic [AW-1:0]    desc_q, first_q, nxt_q, waddr_q;
  logic [DW-1:0]    fst_flg_q, cur_flg_q, nxt_flg_q, cnt_q;

  logic             gate_ok, ack;
  logic [SZW-1:0]   trunc, size_w, chunk_n;
  logic [AW-1:0]    buf_ofs, cnt_ofs;
  rxr_state_e       drain_nxt;
  logic [DW-1:0]    rel_word;

  assign gate_ok = (ring_base_i != '0) && rx_en_i &&
                   (layout_i == STYLE_SEQ || layout_i == STYLE_SWAP);
  assign trunc   = (frm_len_i > MAXL) ? SZW'(MAX_FRAME) : SZW'(frm_len_i);
  assign size_w  = SZW'(0) - cur_flg_q[SZW-1:0];
  assign chunk_n = (size_w < store_q) ? size_w : store_q;
  assign buf_ofs = sty3_q ? AW'(8) : AW'(0);
  assign cnt_ofs = sty3_q ? AW'(0) : AW'(8);
  assign drain_nxt = (remain_q != '0) ? S_DRAIN : S_IDLE;
  assign ack     = mem_req_o && mem_ack_i;

  always_comb begin
    rel_word = fst_flg_q;
    rel_word[STP_B] = 1'b1;
    rel_word[OWN_B] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      after_q    <= AFT_BUF;
      remain_q   <= '0;
      store_q    <= '0;
      tot_q      <= '0;
      chunk_q    <= '0;
      sty3_q     <= 1'b0;
      is_first_q <= 1'b0;
      rint_q     <= 1'b0;
      desc_q     <= '0;
      first_q    <= '0;
      nxt_q      <= '0;
      waddr_q    <= '0;
      fst_flg_q  <= '0;
      cur_flg_q  <= '0;
      nxt_flg_q  <= '0;
      cnt_q      <= '0;
    end else begin
      rint_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (frm_start_i) begin
          remain_q <= frm_len_i;
          store_q  <= trunc;
          tot_q    <= trunc;
          sty3_q   <= (layout_i == STYLE_SWAP);
          if (gate_ok) begin
            desc_q     <= cur_addr_i;
            first_q    <= cur_addr_i;
            is_first_q <= 1'b1;
            state_q    <= S_RD_FLG;
          end else begin
            state_q <= (frm_len_i != '0) ? S_DRAIN : S_IDLE;
          end
        end
        S_RD_FLG: if (ack) begin
          if (mem_rdata_i[OWN_B]) begin
            fst_flg_q <= mem_rdata_i;
            cur_flg_q <= mem_rdata_i;
            state_q   <= S_RD_BUF;
          end else begin
            state_q <= drain_nxt;
          end
        end
        S_RD_BUF: if (ack) begin
          waddr_q <= mem_rdata_i;
          chunk_q <= chunk_n;
          state_q <= (chunk_n == '0) ? S_ADV : S_FILL;
        end
        S_FILL: if (byte_valid_i) begin
          store_q  <= store_q - 1'b1;
          remain_q <= remain_q - 1'b1;
          chunk_q  <= chunk_q - 1'b1;
          if (pk_lane_i == LW'(NB-1) || chunk_q == SZW'(1)) state_q <= S_WR_DAT;
        end
        S_WR_DAT: if (ack) begin
          waddr_q <= waddr_q + AW'(NB);
          state_q <= (chunk_q == '0) ? S_ADV : S_FILL;
        end
        S_ADV: begin
          nxt_q <= nxt_addr_i;
          if (store_q == '0) begin
            if (is_first_q) begin
              fst_flg_q[ENP_B] <= 1'b1;
              state_q <= S_RD_CNT;
            end else begin
              cur_flg_q[ENP_B] <= 1'b1;
              cur_flg_q[OWN_B] <= 1'b0;
              after_q <= AFT_CNT;
              state_q <= S_WR_CUR;
            end
          end else begin
            state_q <= S_RD_NXT;
          end
        end
        S_RD_NXT: if (ack) begin
          if (mem_rdata_i[OWN_B]) begin
            nxt_flg_q <= mem_rdata_i;
            if (is_first_q) begin
              desc_q     <= nxt_q;
              cur_flg_q  <= mem_rdata_i;
              is_first_q <= 1'b0;
              state_q    <= S_RD_BUF;
            end else begin
              cur_flg_q[OWN_B] <= 1'b0;
              after_q <= AFT_BUF;
              state_q <= S_WR_CUR;
            end
          end else if (is_first_q) begin
            fst_flg_q[ERR_B] <= 1'b1;
            fst_flg_q[BUF_B] <= 1'b1;
            fst_flg_q[ENP_B] <= 1'b1;
            state_q <= S_WR_FST;
          end else begin
            cur_flg_q[OWN_B] <= 1'b0;
            cur_flg_q[ERR_B] <= 1'b1;
            cur_flg_q[BUF_B] <= 1'b1;
            cur_flg_q[ENP_B] <= 1'b1;
            after_q <= AFT_FST;
            state_q <= S_WR_CUR;
          end
        end
        S_WR_CUR: if (ack) begin
          unique case (after_q)
            AFT_BUF: begin
              desc_q     <= nxt_q;
              cur_flg_q  <= nxt_flg_q;
              is_first_q <= 1'b0;
              state_q    <= S_RD_BUF;
            end
            AFT_CNT: state_q <= S_RD_CNT;
            default: state_q <= S_WR_FST;
          endcase
        end
        S_RD_CNT: if (ack) begin
          cnt_q   <= {mem_rdata_i[DW-1:SZW], tot_q + SZW'(4)};
          state_q <= S_WR_CNT;
        end
        S_WR_CNT: if (ack) state_q <= S_WR_FST;
        S_WR_FST: if (ack) begin
          rint_q  <= 1'b1;
          state_q <= drain_nxt;
        end
        S_DRAIN: if (byte_valid_i) begin
          remain_q <= remain_q - 1'b1;
          if (remain_q == LEN_W'(1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q + AW'(4);
    mem_wdata_o = '0;
    mem_be_o    = '1;
    unique case (state_q)
      S_RD_FLG: mem_req_o = 1'b1;
      S_RD_BUF: begin mem_req_o = 1'b1; mem_addr_o = desc_q + buf_ofs; end
      S_WR_DAT: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = waddr_q;
        mem_wdata_o = pk_word_i; mem_be_o = pk_be_i;
      end
      S_RD_NXT: begin mem_req_o = 1'b1; mem_addr_o = nxt_q + AW'(4); end
      S_WR_CUR: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = cur_flg_q; end
      S_RD_CNT: begin mem_req_o = 1'b1; mem_addr_o = desc_q + cnt_ofs; end
      S_WR_CNT: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = desc_q + cnt_ofs;
        mem_wdata_o = cnt_q;
      end
      S_WR_FST: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = first_q + AW'(4);
        mem_wdata_o = rel_word;
      end
      default: ;
    endcase
  end

  assign frm_ready_o  = (state_q == S_IDLE);
  assign byte_ready_o = (state_q == S_FILL) || (state_q == S_DRAIN);
  assign pk_load_o    = (state_q == S_FILL) && byte_valid_i;
  assign pk_clr_o     = (state_q == S_WR_DAT) && ack;
  assign adv_o        = (state_q == S_ADV);
  assign rint_o       = rint_q;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer import rxr_pkg::*; #(
  parameter int AW        = 32,
  parameter int POS_W     = 9,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 2048,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ring_base_i,
  input  logic [POS_W:0]   ring_len_i,
  input  logic [7:0]       layout_i,
  input  logic             rx_en_i,
  input  logic             frm_start_i,
  input  logic [LEN_W-1:0] frm_len_i,
  output logic             frm_ready_o,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             byte_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [NB-1:0]    mem_be_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             rint_o
);
  logic [AW-1:0] cur_addr, nxt_addr;
  logic          adv, pk_load, pk_clr;
  logic [DW-1:0] pk_word;
  logic [NB-1:0] pk_be;
  logic [LW-1:0] pk_lane;

  rxr_pos #(.AW(AW), .POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni, .base_i(ring_base_i), .len_i(ring_len_i), .adv_i(adv),
    .cur_addr_o(cur_addr), .nxt_addr_o(nxt_addr)
  );

  rxr_pack #(.NB(NB)) u_pack (
    .clk_i, .rst_ni, .load_i(pk_load), .byte_i, .clr_i(pk_clr),
    .word_o(pk_word), .be_o(pk_be), .lane_o(pk_lane)
  );

  rxr_ctrl #(.AW(AW), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .NB(NB)) u_ctrl (
    .clk_i, .rst_ni, .ring_base_i, .layout_i, .rx_en_i, .frm_start_i, .frm_len_i,
    .frm_ready_o, .byte_valid_i, .byte_ready_o,
    .pk_word_i(pk_word), .pk_be_i(pk_be), .pk_lane_i(pk_lane),
    .pk_load_o(pk_load), .pk_clr_o(pk_clr),
    .cur_addr_i(cur_addr), .nxt_addr_i(nxt_addr), .adv_o(adv),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_be_o,
    .mem_ack_i, .mem_rdata_i, .rint_o
  );
endmodule

// File: rtl/rxr_writer_chk.sv
module rxr_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] ring_base_i,
  input logic          rx_en_i,
  input logic          frm_start_i,
  input logic          frm_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          rint_o
);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_rint_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rint_o |=> !rint_o);

  assert_rint_after_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rint_o |-> $past(mem_req_o && mem_we_o && mem_ack_i &&
                     !mem_wdata_o[31] && mem_wdata_o[25]));

  assert_gate_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_ready_o && frm_start_i && (ring_base_i == '0 || !rx_en_i) |=> !mem_req_o);
endmodule

bind rx_ring_writer rxr_writer_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .ring_base_i, .rx_en_i, .frm_start_i, .frm_ready_o,
  .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .rint_o
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int CLK_P = 10;
  localparam int MW    = 2048;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] FILLV = 32'hAAAA_AAAA;

  logic clk = 0, rst_n = 0;
  logic [31:0] ring_base;
  logic [9:0]  ring_len;
  logic [7:0]  layout;
  logic rx_en, frm_start, frm_ready, bvalid, bready;
  logic [15:0] frm_len;
  logic [7:0]  bdata;
  logic mem_req, mem_we, mack;
  logic [31:0] mem_addr, mem_wdata, mrdata;
  logic [3:0]  mem_be;
  logic rint;

  always #(CLK_P/2) clk = ~clk;

  rx_ring_writer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(ring_base), .ring_len_i(ring_len),
    .layout_i(layout), .rx_en_i(rx_en), .frm_start_i(frm_start), .frm_len_i(frm_len),
    .frm_ready_o(frm_ready), .byte_valid_i(bvalid), .byte_i(bdata), .byte_ready_o(bready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_ack_i(mack), .mem_rdata_i(mrdata), .rint_o(rint)
  );

  // memory model
  logic [31:0] mem [MW];
  logic        fill_en = 0, pk_en = 0;
  logic [31:0] pk_a = 0, pk_d = 0;
  int lat = 0, lat_cnt = 0, wr_n = 0, rd_n = 0, rint_n = 0, rint_wr = 0;
  logic [31:0] lg_a [8];

  always @(posedge clk) begin
    mack <= 1'b0;
    if (fill_en) begin
      for (int i = 0; i < MW; i++) mem[i] <= FILLV;
    end else if (pk_en) begin
      mem[pk_a[12:2]] <= pk_d;
    end else if (mem_req && !mack) begin
      if (lat_cnt == lat) begin
        mack <= 1'b1;
        lat_cnt <= 0;
        mrdata <= mem[mem_addr[12:2]];
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[12:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
          lg_a[wr_n % 8] <= mem_addr;
          wr_n <= wr_n + 1;
        end else begin
          rd_n <= rd_n + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
    if (rint) begin
      rint_n  <= rint_n + 1;
      rint_wr <= wr_n;
    end
  end

  // request stability monitor
  int hold_viol = 0;
  logic pend = 0;
  logic [31:0] pend_a = 0;
  logic pend_w = 0;
  always @(negedge clk) begin
    if (pend && (!mem_req || mem_addr !== pend_a || mem_we !== pend_w)) hold_viol++;
    pend   = mem_req && !mack;
    pend_a = mem_addr;
    pend_w = mem_we;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(logic [31:0] a);
    return mem[a[12:2]];
  endfunction

  task automatic poke(logic [31:0] a, logic [31:0] d);
    @(negedge clk); pk_en = 1; pk_a = a; pk_d = d;
    @(negedge clk); pk_en = 0;
  endtask

  task automatic fill_mem();
    @(negedge clk); fill_en = 1;
    @(negedge clk); fill_en = 0;
  endtask

  function automatic logic [31:0] flg(bit own, int size);
    logic [11:0] f;
    f = 12'(0 - size);
    return {own, 19'd0, f};
  endfunction

  task automatic set_desc(int idx, logic [31:0] ba, int size, bit own, int sty,
                          logic [31:0] cnt_hi);
    logic [31:0] a;
    a = BASE + 32'(16 * idx);
    poke(a + 4, flg(own, size));
    if (sty == 2) begin poke(a, ba); poke(a + 8, cnt_hi); end
    else          begin poke(a + 8, ba); poke(a, cnt_hi); end
    poke(a + 12, 32'h0);
  endtask

  task automatic run_frame(int len, int seed);
    @(negedge clk);
    while (!frm_ready) @(negedge clk);
    frm_start = 1; frm_len = 16'(len);
    @(negedge clk);
    frm_start = 0;
    for (int i = 0; i < len; i++) begin
      bvalid = 1; bdata = 8'(seed + i);
      while (!bready) @(negedge clk);
      @(negedge clk);
    end
    bvalid = 0;
    while (!frm_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset req", {31'd0, mem_req}, 32'd0);
    chk("R11 reset ready", {31'd0, frm_ready}, 32'd1);
    chk("R10 reset rint", {31'd0, rint}, 32'd0);
    chk("R1 reset byte ready", {31'd0, bready}, 32'd0);
  endtask

  task automatic t_single_style2();
    int r0;
    fill_mem();
    layout = 8'd2;
    set_desc(0, 32'h400, 64, 1, 2, 32'h1234_F000);
    r0 = rint_n;
    run_frame(10, 8'h10);
    chk("R5 word0", rdm(32'h400), 32'h1312_1110);
    chk("R5 word1", rdm(32'h404), 32'h1716_1514);
    chk("R5 partial be", rdm(32'h408), 32'hAAAA_1918);
    chk("R5 beyond frame", rdm(32'h40C), FILLV);
    chk("R10 first flags", rdm(32'h104), 32'h0300_0FC0);
    chk("R9 count style2", rdm(32'h108), 32'h1234_F00E);
    chk("R10 one rint", 32'(rint_n - r0), 32'd1);
    chk("R10 last write first desc", lg_a[(wr_n - 1) % 8], 32'h104);
    chk("R9 count before release", lg_a[(wr_n - 2) % 8], 32'h108);
    chk("R10 rint after all writes", 32'(rint_wr), 32'(wr_n));
  endtask

  task automatic t_chain();
    fill_mem();
    set_desc(1, 32'h500, 8, 1, 2, 32'h0);
    set_desc(2, 32'h600, 8, 1, 2, 32'h0);
    set_desc(3, 32'h700, 8, 1, 2, 32'h0);
    run_frame(20, 8'h40);
    chk("R10 chain first flags", rdm(32'h114), 32'h0200_0FF8);
    chk("R7 middle flags", rdm(32'h124), 32'h0000_0FF8);
    chk("R7 R9 last flags", rdm(32'h134), 32'h0100_0FF8);
    chk("R9 chain count", rdm(32'h138), 32'h0000_0018);
    chk("R5 chain buf1", rdm(32'h504), 32'h4746_4544);
    chk("R5 chain buf3", rdm(32'h700), 32'h5352_5150);
    chk("R5 chain buf3 tail", rdm(32'h704), FILLV);
    chk("R10 chain last write", lg_a[(wr_n - 1) % 8], 32'h114);
  endtask

  task automatic t_wrap_style3();
    fill_mem();
    layout = 8'd3;
    set_desc(0, 32'h400, 16, 1, 3, 32'hABCD_E000);
    run_frame(4, 8'h80);
    chk("R2 wrap to desc0", rdm(32'h104), 32'h0300_0FF0);
    chk("R3 style3 buffer", rdm(32'h400), 32'h8382_8180);
    chk("R3 R9 style3 count", rdm(32'h100), 32'hABCD_E008);
    layout = 8'd2;
  endtask

  task automatic t_not_owned();
    int r0, w0, i0;
    fill_mem();
    set_desc(1, 32'h500, 8, 0, 2, 32'h0);
    r0 = rd_n; w0 = wr_n; i0 = rint_n;
    run_frame(6, 8'h00);
    chk("R4 single read", 32'(rd_n - r0), 32'd1);
    chk("R4 no write", 32'(wr_n - w0), 32'd0);
    chk("R4 no rint", 32'(rint_n - i0), 32'd0);
    chk("R4 flags intact", rdm(32'h114), 32'h0000_0FF8);
  endtask

  task automatic t_exhaust();
    int i0;
    fill_mem();
    set_desc(1, 32'h500, 4, 1, 2, 32'h0);
    set_desc(2, 32'h600, 8, 0, 2, 32'h0);
    i0 = rint_n;
    run_frame(10, 8'h20);
    chk("R4 R8 same desc reused, err flags", rdm(32'h114), 32'h4700_0FFC);
    chk("R8 stored part", rdm(32'h500), 32'h2322_2120);
    chk("R8 no spill", rdm(32'h504), FILLV);
    chk("R8 next untouched", rdm(32'h124), 32'h0000_0FF8);
    chk("R8 rint", 32'(rint_n - i0), 32'd1);
  endtask

  task automatic t_gate();
    int r0, w0, i0;
    r0 = rd_n; w0 = wr_n; i0 = rint_n;
    rx_en = 0;
    run_frame(5, 0);
    chk("R1 disabled no access", 32'(rd_n + wr_n - r0 - w0), 32'd0);
    rx_en = 1; ring_base = 32'h0;
    run_frame(5, 0);
    chk("R1 zero base no access", 32'(rd_n + wr_n - r0 - w0), 32'd0);
    ring_base = BASE; layout = 8'd5;
    run_frame(5, 0);
    chk("R1 bad style no access", 32'(rd_n + wr_n - r0 - w0), 32'd0);
    chk("R1 no rint", 32'(rint_n - i0), 32'd0);
    chk("R1 back to idle", {31'd0, frm_ready}, 32'd1);
    layout = 8'd2;
  endtask

  task automatic t_truncate();
    fill_mem();
    lat = 3;
    set_desc(2, 32'h800, 2048, 1, 2, 32'h0);
    run_frame(2060, 0);
    chk("R6 count", rdm(32'h128), 32'h0000_0804);
    chk("R2 R6 flags", rdm(32'h124), 32'h0300_0800);
    chk("R6 first word", rdm(32'h800), 32'h0302_0100);
    chk("R6 last word", rdm(32'h800 + 2044), 32'hFFFE_FDFC);
    chk("R6 nothing past 2048", rdm(32'h1000), FILLV);
    chk("R11 request held", 32'(hold_viol), 32'd0);
    lat = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    ring_base = BASE; ring_len = 10'd4; layout = 8'd2; rx_en = 1;
    frm_start = 0; frm_len = 0; bvalid = 0; bdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_style2();
    t_chain();
    t_wrap_style3();
    t_not_owned();
    t_exhaust();
    t_gate();
    t_truncate();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule